// File: doc/BRIEF.md
# RTC Update Cycle Controller

This block schedules the once-per-second update of a real-time clock's time and calendar counters. It counts pulses of a 32.768 kHz time base presented as a one-cycle `tick_i` enable. Each time a full second of ticks has gone by, it issues a one-cycle strobe to the counters. One cycle after that strobe it raises an update-ended event. The counters and the calendar arithmetic sit outside this block.

Before each strobe, the block raises an update-in-progress status (UIP). UIP goes high a fixed number of base ticks ahead of the strobe. While UIP is low, software knows that no update can begin for at least that many ticks. The default is 8 ticks, about 244 µs.

A SET control stops updates so that software can load the time. While SET is high, the divider is held cleared and UIP is held low. An update-ended flag (UF) is masked by its own enable (UIE) onto an active-low interrupt line. A flag read clears UF.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: While SET is 0, `upd_strobe_o` pulses for exactly one cycle once every `TICKS_PER_SEC` ticks. The first strobe after SET is released falls in the cycle after the edge that samples the `TICKS_PER_SEC`-th tick since the release.
- R2: While SET is 1, `upd_strobe_o` stays 0 and the divider is held at the start of a second.
- R3: `uip_o` rises on the edge that samples tick number `TICKS_PER_SEC - LEAD_TICKS` of a second. It is therefore high for exactly `LEAD_TICKS` ticks before the strobe, and it is still high during the strobe cycle.
- R4: `uip_o` is 0 in the cycle after the strobe. It stays low until the next lead window of R3.
- R5: A write with SET = 1 clears `uip_o` on the same edge at which `set_o` becomes 1. UIP stays 0 while SET is 1.
- R6: Reset does not change SET, UIP or the divider phase. An update already announced by UIP still occurs on schedule across a reset pulse.
- R7: `upd_done_o` pulses in the cycle after each strobe. UF becomes 1 on the next edge, whatever the value of UIE.
- R8: A flag read (`rd_flags_i`) clears UF. If the read falls in the cycle in which `upd_done_o` is high, UF ends up set, because the event wins.
- R9: Reset clears UIE. A bus write loads SET and UIE together from `wr_set_i` and `wr_uie_i`. A write that takes SET from 0 to 1 clears UIE, even when the same write carries `wr_uie_i` = 1.
- R10: `irq_no` is 0 exactly when UF = 1 and UIE = 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per time-base tick |
| wr_en_i | input | 1 | Control register write strobe |
| wr_set_i | input | 1 | SET value written |
| wr_uie_i | input | 1 | UIE value written |
| rd_flags_i | input | 1 | Flag register read strobe, clears UF |
| set_o | output | 1 | Current SET value |
| uie_o | output | 1 | Current UIE value |
| uip_o | output | 1 | Update-in-progress status |
| uf_o | output | 1 | Update-ended flag |
| upd_strobe_o | output | 1 | Update strobe to the counters |
| upd_done_o | output | 1 | Update-ended event |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a flag read and the update-ended event that sets UF. The bench waits for a strobe, then asserts `rd_flags_i` in exactly the done cycle. It expects UF to stay set and the interrupt to stay low, and only a later read clears the flag.

The second pair is a SET write and a live UIP window. The bench writes SET = 1 while UIP is high. It expects UIP and UIE to fall on that same edge, and no strobe over the following two seconds of ticks.

A cycle-accurate tick-phase model, built from the requirements, runs beside these directed checks and judges every output in every cycle.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  typedef struct packed {
    logic set;
    logic uie;
  } ctrl_wr_t;
endpackage

// File: rtl/rtc_upd_ctrl_regs.sv
module rtc_upd_ctrl_regs
  import rtc_upd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  ctrl_wr_t wr_i,
  output logic     set_o,
  output logic     set_d_o,
  output logic     uie_o
);
  logic set_q, uie_q;

  assign set_d_o = wr_en_i ? wr_i.set : set_q;

  // SET keeps its value through reset
  always_ff @(posedge clk_i) set_q <= set_d_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   uie_q <= 1'b0;
    else if (set_d_o && !set_q)    uie_q <= 1'b0;
    else if (wr_en_i)              uie_q <= wr_i.uie;
  end

  assign set_o = set_q;
  assign uie_o = uie_q;
endmodule

// File: rtl/rtc_upd_divider.sv
module rtc_upd_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8
) (
  input  logic clk_i,
  input  logic tick_i,
  input  logic inhibit_i,
  output logic uip_o,
  output logic strobe_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] UIP_PH  = CNT_W'(TICKS_PER_SEC - 1 - LEAD_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic uip_q, strobe_q, done_q;
  logic at_last, at_uip;

  assign at_last = tick_i && (cnt_q == LAST_PH);
  assign at_uip  = tick_i && (cnt_q == UIP_PH);

  // timing chain is not reset: it belongs to the always-on time base
  always_ff @(posedge clk_i) begin
    done_q <= strobe_q;
    if (inhibit_i) begin
      cnt_q    <= '0;
      uip_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= at_last;
      if (tick_i) cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
      if (at_uip)        uip_q <= 1'b1;
      else if (strobe_q) uip_q <= 1'b0;
    end
  end

  assign uip_o    = uip_q;
  assign strobe_o = strobe_q;
  assign done_o   = done_q;
endmodule

// File: rtl/rtc_upd_flags.sv
module rtc_upd_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic rd_i,
  input  logic uie_i,
  output logic uf_o,
  output logic irq_no
);
  logic uf_q;

  // event beats a coinciding read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     uf_q <= 1'b0;
    else if (done_i) uf_q <= 1'b1;
    else if (rd_i)   uf_q <= 1'b0;
  end

  assign uf_o   = uf_q;
  assign irq_no = ~(uf_q & uie_i);
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_en_i,
  input  logic wr_set_i,
  input  logic wr_uie_i,
  input  logic rd_flags_i,
  output logic set_o,
  output logic uie_o,
  output logic uip_o,
  output logic uf_o,
  output logic upd_strobe_o,
  output logic upd_done_o,
  output logic irq_no
);
  ctrl_wr_t wr;
  logic     set_d, done;

  assign wr.set = wr_set_i;
  assign wr.uie = wr_uie_i;

  rtc_upd_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_i    (wr),
    .set_o   (set_o),
    .set_d_o (set_d),
    .uie_o   (uie_o)
  );

  rtc_upd_divider #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .LEAD_TICKS    (LEAD_TICKS)
  ) u_div (
    .clk_i     (clk_i),
    .tick_i    (tick_i),
    .inhibit_i (set_d),
    .uip_o     (uip_o),
    .strobe_o  (upd_strobe_o),
    .done_o    (done)
  );

  rtc_upd_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .rd_i   (rd_flags_i),
    .uie_i  (uie_o),
    .uf_o   (uf_o),
    .irq_no (irq_no)
  );

  assign upd_done_o = done;
endmodule

// File: rtl/rtc_upd_checker.sv
module rtc_upd_checker #(
  parameter int LEAD_TICKS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic set_o,
  input logic uie_o,
  input logic uip_o,
  input logic uf_o,
  input logic upd_strobe_o,
  input logic upd_done_o,
  input logic irq_no
);
  localparam int LC_W = $clog2(LEAD_TICKS + 2);
  logic [LC_W-1:0] lead_cnt;

  always_ff @(posedge clk_i) begin
    if (!uip_o)      lead_cnt <= '0;
    else if (tick_i) lead_cnt <= lead_cnt + LC_W'(1);
  end

  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_strobe_o |=> !upd_strobe_o);
  a_r2_no_strobe_in_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> !upd_strobe_o);
  a_r3_lead_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_strobe_o |-> (uip_o && lead_cnt == LC_W'(LEAD_TICKS)));
  a_r4_uip_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_strobe_o |=> !uip_o);
  a_r5_set_blocks_uip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> !uip_o);
  a_r7_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_strobe_o |=> upd_done_o);
  a_r7_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |=> uf_o);
  a_r9_set_clears_uie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(set_o) |-> !uie_o);
  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uie_o |-> irq_no);
endmodule

bind rtc_upd_ctrl rtc_upd_checker #(.LEAD_TICKS(LEAD_TICKS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .set_o        (set_o),
  .uie_o        (uie_o),
  .uip_o        (uip_o),
  .uf_o         (uf_o),
  .upd_strobe_o (upd_strobe_o),
  .upd_done_o   (upd_done_o),
  .irq_no       (irq_no)
);

// File: tb/rtc_upd_ctrl_tb_top.sv
module rtc_upd_ctrl_tb_top;
  localparam int N    = 64;
  localparam int LEAD = 8;
  localparam int TP   = 4;       // clocks per tick
  localparam int SEC  = N * TP;  // clocks per second

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic wr_en_i = 1'b0, wr_set_i = 1'b0, wr_uie_i = 1'b0, rd_flags_i = 1'b0;
  logic set_o, uie_o, uip_o, uf_o, upd_strobe_o, upd_done_o, irq_no;

  int checks = 0, errors = 0;
  bit tick_run = 1'b0;
  int tdiv = 0;

  always #10 clk_i = ~clk_i;

  rtc_upd_ctrl #(.TICKS_PER_SEC(N), .LEAD_TICKS(LEAD)) dut_i (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_set_i, .wr_uie_i, .rd_flags_i,
    .set_o, .uie_o, .uip_o, .uf_o, .upd_strobe_o, .upd_done_o, .irq_no
  );

  always @(negedge clk_i) begin
    if (tick_run) begin
      tick_i <= (tdiv == TP - 1);
      tdiv   <= (tdiv == TP - 1) ? 0 : tdiv + 1;
    end else tick_i <= 1'b0;
  end

  // reference model from the requirements
  bit m_valid = 0, m_set = 0, m_wrap = 0, m_done = 0, m_uf = 0, m_uie = 0;
  int m_phase = 0;
  wire set_n = wr_en_i ? wr_set_i : m_set;

  always @(posedge clk_i) begin
    if (wr_en_i) m_valid <= 1'b1;
    m_set  <= set_n;
    m_done <= m_wrap;
    if (set_n) begin
      m_phase <= 0; m_wrap <= 1'b0;
    end else if (tick_i) begin
      m_phase <= (m_phase == N - 1) ? 0 : m_phase + 1;
      m_wrap  <= (m_phase == N - 1);
    end else m_wrap <= 1'b0;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_uf <= 1'b0; m_uie <= 1'b0;
    end else begin
      if (m_done) m_uf <= 1'b1;
      else if (rd_flags_i) m_uf <= 1'b0;
      if (set_n && !m_set) m_uie <= 1'b0;
      else if (wr_en_i) m_uie <= wr_uie_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (m_valid) begin
      chk("R3/R4/R5 uip", int'(uip_o), int'(!m_set && (m_phase >= N - LEAD || m_wrap)));
      chk("R1/R2 strobe", int'(upd_strobe_o), int'(m_wrap));
      chk("R7 done", int'(upd_done_o), int'(m_done));
      chk("R7/R8 uf", int'(uf_o), int'(m_uf));
      chk("R9 uie", int'(uie_o), int'(m_uie));
      chk("R6 set", int'(set_o), int'(m_set));
      chk("R10 irq", int'(irq_no), int'(!(m_uf && m_uie)));
    end
  end

  task automatic wr(input bit s, input bit u);
    wr_en_i = 1'b1; wr_set_i = s; wr_uie_i = u;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd();
    rd_flags_i = 1'b1;
    @(negedge clk_i);
    rd_flags_i = 1'b0;
  endtask

  task automatic watch(input int n, output int strobes, output int uips, output int dones);
    strobes = 0; uips = 0; dones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      strobes += int'(upd_strobe_o);
      uips    += int'(uip_o);
      dones   += int'(upd_done_o);
    end
  endtask

  task automatic wait_for(input bit want_uip, input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk_i);
      seen = want_uip ? uip_o : upd_strobe_o;
    end
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (SEC * 40) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, u, d;
    bit seen;
    repeat (3) @(negedge clk_i);
    chk("R9 uie after reset", int'(uie_o), 0);
    chk("R10 irq after reset", int'(irq_no), 1);
    chk("R7 uf after reset", int'(uf_o), 0);
    wr(1'b1, 1'b1);
    chk("R9 uie held in reset", int'(uie_o), 0);
    rst_ni = 1'b1;
    tick_run = 1'b1;
    chk("R6 set written in reset", int'(set_o), 1);

    watch(2 * SEC, s, u, d);
    chk("R2 no strobe under set", s, 0);
    chk("R5 no uip under set", u, 0);

    wr(1'b0, 1'b1);
    watch(3 * SEC + 100, s, u, d);
    chk("R1 strobes in three seconds", s, 3);
    chk("R3 uip cycles per second window", u, 3 * (LEAD * TP + 1));
    chk("R10 irq low with uf and uie", int'(irq_no), 0);
    rd();
    chk("R8 read clears uf", int'(uf_o), 0);
    chk("R10 irq released", int'(irq_no), 1);

    // read coinciding with the update-ended event
    wait_for(1'b0, 2 * SEC, seen);
    chk("R1 strobe arrives", int'(seen), 1);
    @(negedge clk_i);
    chk("R7 done after strobe", int'(upd_done_o), 1);
    rd();
    chk("R8 event wins over read", int'(uf_o), 1);
    chk("R10 irq with coinciding read", int'(irq_no), 0);
    rd();
    chk("R8 second read clears", int'(uf_o), 0);

    // SET during UIP window
    wait_for(1'b1, 2 * SEC, seen);
    chk("R3 uip rises", int'(seen), 1);
    repeat (3) @(negedge clk_i);
    wr(1'b1, 1'b1);
    chk("R5 uip cleared by set", int'(uip_o), 0);
    chk("R9 set rise clears uie", int'(uie_o), 0);
    watch(2 * SEC + 64, s, u, d);
    chk("R2 no strobe after set", s, 0);
    chk("R5 uip stays low", u, 0);

    // reset during UIP window
    wr(1'b0, 1'b1);
    wait_for(1'b1, 2 * SEC, seen);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R6 uip survives reset", int'(uip_o), 1);
    chk("R6 set survives reset", int'(set_o), 0);
    chk("R9 reset clears uie", int'(uie_o), 0);
    rst_ni = 1'b1;
    wait_for(1'b0, LEAD * TP + 16, seen);
    chk("R6 strobe on schedule after reset", int'(seen), 1);

    wr(1'b1, 1'b0);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R6 set retained through reset", int'(set_o), 1);

    // UF without UIE
    wr(1'b0, 1'b0);
    watch(SEC + 40, s, u, d);
    chk("R7 one update ended", d, 1);
    chk("R7 uf set without uie", int'(uf_o), 1);
    chk("R10 irq masked", int'(irq_no), 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule